// File: doc/BRIEF.md
# Maskable Interrupt Source Register Set

This block collects ten interrupt sources into a status register and drives one level-sensitive interrupt line towards a processor. A pulse on a hardware event input latches the matching status bit. Software sees the block through a simple register port: one write strobe, a byte address and write data, with read data returned combinationally for the addressed word. Writing 1s to the status word clears the matching pending bits.

The mask cannot be written directly. Software unmasks sources by writing 1s to an enable word and masks them by writing 1s to a disable word, so one source can be changed without a read-modify-write of the others. After reset every source is masked. A trigger word lets software set status bits, which is used to test the interrupt path without real events. The interrupt line is high whenever any pending source is unmasked.

Top module: `irq_ctrl_regs`

## Requirements
- R1: After reset the status word reads 0x000, the mask word reads 0x3FF (all sources masked) and the interrupt output is low.
- R2: Writing to byte offset 0x00 (status) clears every status bit [9:0] where the write data holds a 1. Bits written as 0 keep their value.
- R3: A high level on hardware event input bit i in a clock cycle makes status bit i read 1 from the next cycle on.
- R4: When a hardware event and a status clear write hit the same bit in the same cycle, the bit reads 1 afterwards.
- R5: Writing to byte offset 0x08 (enable) clears the mask bits where the write data holds a 1. Other mask bits are unchanged.
- R6: Writing to byte offset 0x0C (disable) sets the mask bits where the write data holds a 1. Other mask bits are unchanged.
- R7: Writing to byte offset 0x10 (trigger) sets the status bits where the write data holds a 1. Other status bits are unchanged.
- R8: A write to byte offset 0x04 (mask) has no effect on the mask.
- R9: The interrupt output equals the OR over i of (status[i] AND NOT mask[i]). It takes its new value in the cycle after the write or event that changes status or mask.
- R10: The enable, disable and trigger words read as zero. Any unmapped offset from 0x14 to 0x1C also reads as zero.
- R11: Read data bits [31:10] are always zero. Write data bits [31:10] change no state at any offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | 5 | Byte address of the register access (bits [1:0] ignored) |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data of the addressed word, combinational |
| hw_event_i | input | 10 | Hardware event inputs, one per source |
| irq_o | output | 1 | Level interrupt output |

## Verification
Assertions check on every cycle that an event always leaves its status bit set, even against a clear write, that status bits drop and the mask changes only under the matching write strobes, that the interrupt line agrees with the registered status and mask, and that reserved and write-only read data stays zero. Only the bench scenarios show the values themselves: the reset pattern, the per-source sweep through trigger, enable, disable and clear, the ignored direct mask write, and a long pseudo-random mix of writes and events compared against a model written from the requirements.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

    // Word index of each register (byte address bits [4:2]).
    localparam int unsigned REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_STATUS  = 3'd0,
        REG_MASK    = 3'd1,
        REG_ENABLE  = 3'd2,
        REG_DISABLE = 3'd3,
        REG_TRIGGER = 3'd4
    } reg_sel_e;

    // One strobe per register with a write side effect.
    typedef struct packed {
        logic clr;
        logic en;
        logic dis;
        logic trig;
    } wr_strobe_t;

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
    import irq_regs_pkg::*;
(
    input  logic                 wr_en_i,
    input  logic [REG_IDX_W-1:0] idx_i,
    output wr_strobe_t           strb_o
);

    always_comb begin
        strb_o = '0;
        if (wr_en_i) begin
            case (reg_sel_e'(idx_i))
                REG_STATUS:  strb_o.clr  = 1'b1;
                REG_ENABLE:  strb_o.en   = 1'b1;
                REG_DISABLE: strb_o.dis  = 1'b1;
                REG_TRIGGER: strb_o.trig = 1'b1;
                default:     strb_o      = '0;
            endcase
        end
    end

    // At most one strobe fires per write (R8: mask word has no strobe).
    always_comb begin
        assert ($onehot0(strb_o))
            else $error("p_one_strobe_r8");
    end

endmodule

// File: rtl/irq_src_state.sv
module irq_src_state
    import irq_regs_pkg::*;
#(
    parameter int unsigned NUM_SRC = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  wr_strobe_t         strb_i,
    input  logic [NUM_SRC-1:0] wr_bits_i,
    input  logic [NUM_SRC-1:0] hw_event_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] mask;
        logic               irq;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] status_nxt;
    logic [NUM_SRC-1:0] mask_nxt;

    // Per-source next values: the event term is ORed last so it wins
    // over a clear in the same cycle.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic clr_bit, set_bit, unmask_bit, mask_bit;
        assign clr_bit    = strb_i.clr  & wr_bits_i[i];
        assign set_bit    = (strb_i.trig & wr_bits_i[i]) | hw_event_i[i];
        assign unmask_bit = strb_i.en   & wr_bits_i[i];
        assign mask_bit   = strb_i.dis  & wr_bits_i[i];
        assign status_nxt[i] = (st_q.status[i] & ~clr_bit) | set_bit;
        assign mask_nxt[i]   = (st_q.mask[i] & ~unmask_bit) | mask_bit;
    end

    always_comb begin
        st_d        = st_q;
        st_d.status = status_nxt;
        st_d.mask   = mask_nxt;
        st_d.irq    = |(status_nxt & ~mask_nxt);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.status <= '0;
            st_q.mask   <= '1;
            st_q.irq    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = st_q.irq;

    // R3 and R4: an event always leaves its bit set, clear or not.
    p_event_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_event_i != '0) |=> ((st_q.status & $past(hw_event_i)) == $past(hw_event_i)))
        else $error("p_event_sets_r4");

    // R2: status bits fall only under a status clear write.
    p_clear_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strb_i.clr |=> ((st_q.status & $past(st_q.status)) == $past(st_q.status)))
        else $error("p_clear_only_r2");

    // R8: mask moves only under an enable or disable write.
    p_mask_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(strb_i.en || strb_i.dis) |=> $stable(st_q.mask))
        else $error("p_mask_hold_r8");

    // R7: a trigger write cannot lower any status bit.
    p_trig_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strb_i.trig |=> ((st_q.status & $past(wr_bits_i)) == $past(wr_bits_i)))
        else $error("p_trig_sets_r7");

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
    import irq_regs_pkg::*;
#(
    parameter int unsigned NUM_SRC = 10,
    parameter int unsigned DATA_W  = 32
) (
    input  logic [REG_IDX_W-1:0] idx_i,
    input  logic [NUM_SRC-1:0]   status_i,
    input  logic [NUM_SRC-1:0]   mask_i,
    output logic [DATA_W-1:0]    rd_data_o
);

    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    logic [NUM_SRC-1:0] field;

    always_comb begin
        case (reg_sel_e'(idx_i))
            REG_STATUS: field = status_i;
            REG_MASK:   field = mask_i;
            default:    field = '0;
        endcase
        rd_data_o = {{PAD_W{1'b0}}, field};
    end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_regs_pkg::*;
#(
    parameter int unsigned NUM_SRC = 10,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [NUM_SRC-1:0] hw_event_i,
    output logic              irq_o
);

    localparam int unsigned BYTE_SEL_W = 2;

    logic [REG_IDX_W-1:0] idx;
    wr_strobe_t           strb;
    logic [NUM_SRC-1:0]   status_q;
    logic [NUM_SRC-1:0]   mask_q;
    logic [NUM_SRC-1:0]   wr_bits;
    logic                 unused_bits;

    assign idx         = addr_i[BYTE_SEL_W +: REG_IDX_W];
    assign wr_bits     = wr_data_i[NUM_SRC-1:0];
    assign unused_bits = ^{wr_data_i[DATA_W-1:NUM_SRC], addr_i[BYTE_SEL_W-1:0]};

    irq_wr_decode i_dec (
        .wr_en_i (wr_en_i),
        .idx_i   (idx),
        .strb_o  (strb)
    );

    irq_src_state #(.NUM_SRC(NUM_SRC)) i_state (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .strb_i     (strb),
        .wr_bits_i  (wr_bits),
        .hw_event_i (hw_event_i),
        .status_o   (status_q),
        .mask_o     (mask_q),
        .irq_o      (irq_o)
    );

    irq_rd_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_rd (
        .idx_i     (idx),
        .status_i  (status_q),
        .mask_i    (mask_q),
        .rd_data_o (rd_data_o)
    );

    // R9: the registered line agrees with the stored status and mask.
    p_irq_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == |(status_q & ~mask_q))
        else $error("p_irq_match_r9");

    // R11: reserved read bits stay zero.
    p_rsvd_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[DATA_W-1:NUM_SRC] == '0)
        else $error("p_rsvd_zero_r11");

    // R10: write-only words read zero.
    p_wo_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idx == REG_ENABLE || idx == REG_DISABLE || idx == REG_TRIGGER) |-> rd_data_o == '0)
        else $error("p_wo_zero_r10");

endmodule

// File: tb/test_irq_ctrl_regs.sv
module test_irq_ctrl_regs;

    localparam int NSRC = 10;
    localparam logic [31:0] ALL = 32'h3FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [NSRC-1:0] hw_event = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_status = '0;
    logic [31:0] m_mask   = ALL;

    always #5 clk = ~clk;

    irq_ctrl_regs i_irq_ctrl_regs (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wr_data_i  (wr_data),
        .rd_data_o  (rd_data),
        .hw_event_i (hw_event),
        .irq_o      (irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd_chk(string req, logic [4:0] off, logic [31:0] exp);
        addr = off;
        #1;
        check(req, rd_data, exp);
    endtask

    // One cycle with an optional write and optional events; updates the model.
    task automatic cyc(bit we, logic [4:0] off, logic [31:0] d, logic [NSRC-1:0] ev);
        logic [31:0] b;
        @(negedge clk);
        wr_en = we; addr = off; wr_data = d; hw_event = ev;
        @(negedge clk);
        wr_en = 1'b0; hw_event = '0;
        b = d & ALL;
        if (we) begin
            case (off)
                5'h00: m_status = m_status & ~b;
                5'h08: m_mask   = m_mask & ~b;
                5'h0C: m_mask   = m_mask | b;
                5'h10: m_status = m_status | b;
                default: ;
            endcase
        end
        m_status = m_status | {22'd0, ev};
    endtask

    function automatic logic [31:0] exp_irq();
        return {31'd0, |(m_status & ~m_mask)};
    endfunction

    task automatic chk_all(string req);
        rd_chk({req, " status"}, 5'h00, m_status);
        rd_chk({req, " mask"}, 5'h04, m_mask);
        check({req, " irq R9"}, {31'd0, irq}, exp_irq());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 status", 5'h00, 32'h0);
        rd_chk("R1 mask", 5'h04, ALL);
        check("R1 irq", {31'd0, irq}, 32'h0);

        // R8 direct mask write ignored
        cyc(1, 5'h04, 32'h0, '0);
        rd_chk("R8 mask", 5'h04, ALL);

        // Per-source sweep
        for (int i = 0; i < NSRC; i++) begin
            logic [31:0] bit_i;
            bit_i = 32'h1 << i;
            cyc(1, 5'h10, bit_i, '0);
            chk_all("R7 trigger");
            check("R9 masked irq", {31'd0, irq}, 32'h0);
            cyc(1, 5'h08, bit_i, '0);
            chk_all("R5 enable");
            check("R9 unmasked irq", {31'd0, irq}, 32'h1);
            rd_chk("R10 enable reads zero", 5'h08, 32'h0);
            rd_chk("R10 disable reads zero", 5'h0C, 32'h0);
            rd_chk("R10 trigger reads zero", 5'h10, 32'h0);
            cyc(1, 5'h0C, bit_i, '0);
            chk_all("R6 disable");
            cyc(1, 5'h08, bit_i, '0);
            cyc(1, 5'h00, bit_i, '0);
            chk_all("R2 clear");
            check("R2 status bit", {31'd0, rd_data[i]}, 32'h0);
            cyc(1, 5'h0C, bit_i, '0);
        end

        // R11 reserved write bits have no effect anywhere
        cyc(1, 5'h10, 32'hFFFF_FC00, '0);
        cyc(1, 5'h08, 32'hFFFF_FC00, '0);
        chk_all("R11 reserved write");
        cyc(1, 5'h10, 32'hFFFF_FFFF, '0);
        rd_chk("R11 reserved read", 5'h00, ALL);
        cyc(1, 5'h00, 32'hFFFF_FFFF, '0);
        rd_chk("R2 clear all", 5'h00, 32'h0);

        // R3 events, R9 timing after event
        cyc(1, 5'h08, 32'h005, '0);
        cyc(0, 5'h00, 32'h0, 10'h204);
        chk_all("R3 event");
        check("R9 event irq", {31'd0, irq}, 32'h1);

        // R4 event beats clear on same bit
        cyc(1, 5'h00, 32'h204, 10'h200);
        rd_chk("R4 event wins", 5'h00, 32'h200);
        chk_all("R4");

        // R10 unmapped offsets
        for (int o = 5; o < 8; o++) rd_chk("R10 unmapped", 5'(o * 4), 32'h0);

        // Pseudo-random mix against the model
        begin
            logic [31:0] lfsr;
            lfsr = 32'hACE1_2345;
            for (int n = 0; n < 400; n++) begin
                logic [4:0] off;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                off = {lfsr[2:0], 2'b00};
                cyc(lfsr[3], off, {lfsr[31:16], lfsr[13:4], 6'd0} >> 6,
                    lfsr[4] ? lfsr[25:16] & lfsr[15:6] : '0);
                chk_all("R3 R5 R6 R7 mix");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule